// File: doc/BRIEF.md
# Dual-Modulus Synthesiser Divider Core

This block is the digital heart of one intermediate-frequency phase-locked loop. It has three parts. A swallow-count divider drives the modulus-select line of an external two-modulus prescaler and counts the prescaler's output. A programmable reference divider counts the reference oscillator. A phase-frequency detector compares the two divided edges and produces up/down pump requests and a lock flag.

Both the prescaler output and the reference oscillator reach the block as single-cycle enable strobes (`pre_tick`, `ref_tick`) on one system clock. Every configuration field is a static input. The feedback divide word packs the main count M in bits 17..7 and the swallow count A in bits 6..0. A 3-bit code selects the prescaler modulus pair N/N+1.

The feedback period is M·N + A prescaler input cycles. The block raises a configuration error whenever A is not below N. The pump outputs can be swapped for inverted loop sense or held quiet. The lock flag can be inverted.

Top module: `synth_divider_core`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `mod_ctl`, `fb_pulse`, `ref_pulse`, `pump_up` and `pump_dn` are 0. `pump_en` equals the inverse of `cfg_hiz`, and `lock_det` equals `cfg_lock_inv`.
- R2: `fb_pulse` is high for one cycle after every M-th accepted `pre_tick` (M = `cfg_div[17:7]`). With a prescaler that divides by N+1 while `mod_ctl` is high and by N otherwise, the spacing of `fb_pulse` is M·N + A clock cycles (A = `cfg_div[6:0]`, M ≥ A, M ≥ 1).
- R3: In every feedback period, `mod_ctl` is high for the first A prescaler cycles and low for the remaining M − A. No high cycle follows a low cycle within a period.
- R4: The modulus code maps as follows: `cfg_psc` = 0xx gives N = 8, 100 gives 16, 101 gives 32, 110 gives 64, and 111 gives 128. `cfg_err` is 1 exactly when A ≥ N.
- R5: `ref_pulse` is high for one cycle after every R-th `ref_tick` (R = `cfg_ref`, 15 bits). A value of 0 behaves as 1.
- R6: A reference edge sets the up request and a feedback edge sets the down request. When both are set, both clear on the next cycle. When the feedback runs faster than the reference, down requests occupy far more cycles than up requests.
- R7: With `cfg_pol` = 1, the up and down requests appear swapped on `pump_up` and `pump_dn`.
- R8: With `cfg_hiz` = 1, `pump_en` is 0 and `pump_up` and `pump_dn` stay 0.
- R9: The lock flag rises only after 16 consecutive reference periods in which no pump request stays active across 2 `ref_tick` strobes. It does not rise earlier.
- R10: The lock flag drops on the first pump request that stays active across 2 `ref_tick` strobes. A frequency offset therefore leaves it low.
- R11: `lock_det` is the lock flag XOR `cfg_lock_inv`, so 1 means locked when `cfg_lock_inv` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_tick | input | 1 | One-cycle strobe per prescaler output edge |
| ref_tick | input | 1 | One-cycle strobe per reference oscillator edge |
| cfg_div | input | 18 | Feedback word: M in [17:7], A in [6:0] |
| cfg_psc | input | 3 | Prescaler modulus code |
| cfg_ref | input | 15 | Reference division count R |
| cfg_pol | input | 1 | 1 swaps up and down outputs |
| cfg_hiz | input | 1 | 1 holds the pump outputs inactive |
| cfg_lock_inv | input | 1 | 1 inverts `lock_det` |
| mod_ctl | output | 1 | 1 selects N+1 in the prescaler |
| fb_pulse | output | 1 | Divided feedback edge |
| ref_pulse | output | 1 | Divided reference edge |
| pump_up | output | 1 | Pump up request |
| pump_dn | output | 1 | Pump down request |
| pump_en | output | 1 | Pump drive enable, 0 means high impedance |
| lock_det | output | 1 | Lock indication |
| cfg_err | output | 1 | A is not below N |

## Verification
`fb_pulse` and `ref_pulse` are registered. Each rises one clock after the edge that accepts the final strobe of a period, so the bench measures periods as gaps between pulses sampled on falling edges. After any configuration change it discards the period in flight and checks only the next complete one. The pump outputs follow a divided edge by one more register. The bench therefore judges them by occupancy counted over windows of a few thousand cycles, not in a single cycle. `cfg_err`, polarity, tristate and lock inversion are combinational from inputs and state, and are sampled on the falling edge after the change. Lock is checked well before and well after the 16-period count, never near its boundary.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int unsigned PSC_W  = 3;
  localparam int unsigned NMOD_W = 8;

  // Prescaler base modulus N selected by the code; N+1 is the alternate.
  function automatic logic [NMOD_W-1:0] psc_modulus(input logic [PSC_W-1:0] code);
    logic [NMOD_W-1:0] n;
    if (!code[2]) begin
      n = NMOD_W'(8);
    end else begin
      case (code[1:0])
        2'b00:   n = NMOD_W'(16);
        2'b01:   n = NMOD_W'(32);
        2'b10:   n = NMOD_W'(64);
        default: n = NMOD_W'(128);
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/fb_swallow_div.sv
module fb_swallow_div #(
  parameter int unsigned M_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tick,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  output logic           mod_ctl,
  output logic           fb_pulse
);

  localparam logic [M_W-1:0] M_ONE  = M_W'(1);
  localparam logic [A_W-1:0] A_ZERO = '0;

  logic [M_W-1:0] m_left_q, m_left_d;
  logic [A_W-1:0] a_left_q, a_left_d;
  logic           pulse_q, pulse_d;
  logic           reload;

  assign reload = pre_tick && (m_left_q <= M_ONE);

  always_comb begin
    m_left_d = m_left_q;
    a_left_d = a_left_q;
    pulse_d  = 1'b0;
    if (pre_tick) begin
      if (reload) begin
        m_left_d = cfg_m;
        a_left_d = cfg_a;
        pulse_d  = 1'b1;
      end else begin
        m_left_d = m_left_q - M_ONE;
        if (a_left_q != A_ZERO) begin
          a_left_d = a_left_q - A_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left_q <= '0;
      a_left_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      m_left_q <= m_left_d;
      a_left_q <= a_left_d;
      pulse_q  <= pulse_d;
    end
  end

  assign mod_ctl  = (a_left_q != A_ZERO);
  assign fb_pulse = pulse_q;

  // R3: once the N phase has begun, N+1 does not return before the reload.
  p_swallow_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && !mod_ctl && !reload) |=> !mod_ctl);

  // R2: a feedback edge always follows an accepted prescaler strobe.
  p_fb_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(pre_tick));

endmodule

// File: rtl/ref_div.sv
module ref_div #(
  parameter int unsigned REF_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [REF_W-1:0] cfg_ref,
  output logic             ref_pulse
);

  localparam logic [REF_W-1:0] R_ONE = REF_W'(1);

  logic [REF_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (ref_tick) begin
      if (cnt_q <= R_ONE) begin
        cnt_d   = cfg_ref;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - R_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign ref_pulse = pulse_q;

  p_ref_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));

endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  input  logic pol,
  input  logic hiz,
  output logic req_active,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_en
);

  logic up_q, up_d;
  logic dn_q, dn_d;
  logic clr;

  assign clr = up_q && dn_q;

  always_comb begin
    if (clr) begin
      up_d = ref_ev;
      dn_d = fb_ev;
    end else begin
      up_d = up_q || ref_ev;
      dn_d = dn_q || fb_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign req_active = up_q || dn_q;
  assign pump_en    = !hiz;
  assign pump_up    = !hiz && (pol ? dn_q : up_q);
  assign pump_dn    = !hiz && (pol ? up_q : dn_q);

  // R6: both requests set with no new edge -> both clear next cycle.
  p_pfd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ref_ev && !fb_ev) |=> (!up_q && !dn_q));

  // R6: a reference edge raises the up request.
  p_ref_sets_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ev && !(up_q && dn_q)) |=> up_q);

endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int unsigned LOCK_N = 16,
  parameter int unsigned PW_LIM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic ref_ev,
  input  logic active,
  output logic locked
);

  localparam int unsigned WC_W = $clog2(PW_LIM + 1);
  localparam int unsigned GC_W = $clog2(LOCK_N + 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(PW_LIM - 1);
  localparam logic [GC_W-1:0] GC_FULL = GC_W'(LOCK_N);

  logic [WC_W-1:0] wcnt_q, wcnt_d;
  logic [GC_W-1:0] good_q, good_d;
  logic            seen_q, seen_d;
  logic            lock_q, lock_d;
  logic            viol;

  assign viol = active && ref_tick && (wcnt_q == WC_LAST);

  always_comb begin
    wcnt_d = wcnt_q;
    if (!active) begin
      wcnt_d = '0;
    end else if (ref_tick && (wcnt_q < WC_LAST)) begin
      wcnt_d = wcnt_q + WC_W'(1);
    end
  end

  always_comb begin
    seen_d = ref_ev ? 1'b0 : (seen_q || viol);
    good_d = good_q;
    if (ref_ev) begin
      if (seen_q || viol) begin
        good_d = '0;
      end else if (good_q != GC_FULL) begin
        good_d = good_q + GC_W'(1);
      end
    end
    lock_d = lock_q;
    if (viol) begin
      lock_d = 1'b0;
    end else if (ref_ev) begin
      lock_d = (good_d == GC_FULL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      good_q <= '0;
      seen_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      good_q <= good_d;
      seen_q <= seen_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  p_lock_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !lock_q);

  p_lock_on_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(ref_ev));

endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
  import synth_div_pkg::*;
#(
  parameter int unsigned M_W    = 11,
  parameter int unsigned A_W    = 7,
  parameter int unsigned REF_W  = 15,
  parameter int unsigned LOCK_N = 16,
  parameter int unsigned PW_LIM = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pre_tick,
  input  logic                 ref_tick,
  input  logic [M_W+A_W-1:0]   cfg_div,
  input  logic [PSC_W-1:0]     cfg_psc,
  input  logic [REF_W-1:0]     cfg_ref,
  input  logic                 cfg_pol,
  input  logic                 cfg_hiz,
  input  logic                 cfg_lock_inv,
  output logic                 mod_ctl,
  output logic                 fb_pulse,
  output logic                 ref_pulse,
  output logic                 pump_up,
  output logic                 pump_dn,
  output logic                 pump_en,
  output logic                 lock_det,
  output logic                 cfg_err
);

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;
  logic [M_W-1:0]    cfg_m;
  logic [A_W-1:0]    cfg_a;
  logic [NMOD_W-1:0] nmod;
  logic              req_active;
  logic              locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  assign cfg_m   = cfg_div[M_W+A_W-1:A_W];
  assign cfg_a   = cfg_div[A_W-1:0];
  assign nmod    = psc_modulus(cfg_psc);
  assign cfg_err = (int'(cfg_a) >= int'(nmod));

  fb_swallow_div #(.M_W(M_W), .A_W(A_W)) fb_div_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pre_tick (pre_tick),
    .cfg_m    (cfg_m),
    .cfg_a    (cfg_a),
    .mod_ctl  (mod_ctl),
    .fb_pulse (fb_pulse)
  );

  ref_div #(.REF_W(REF_W)) ref_div_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ref_tick  (ref_tick),
    .cfg_ref   (cfg_ref),
    .ref_pulse (ref_pulse)
  );

  pfd_core pfd_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ref_ev     (ref_pulse),
    .fb_ev      (fb_pulse),
    .pol        (cfg_pol),
    .hiz        (cfg_hiz),
    .req_active (req_active),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_en    (pump_en)
  );

  lock_mon #(.LOCK_N(LOCK_N), .PW_LIM(PW_LIM)) lock_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ref_tick (ref_tick),
    .ref_ev   (ref_pulse),
    .active   (req_active),
    .locked   (locked)
  );

  assign lock_det = locked ^ cfg_lock_inv;

  // R4: the smallest modulus is 8, so an error implies A of at least 8.
  p_cfg_err_floor_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_err |-> (int'(cfg_a) >= 8));

endmodule

// File: tb/synth_divider_core_tb_top.sv
module synth_divider_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic        pre_tick, ref_tick;
  logic [17:0] cfg_div;
  logic [2:0]  cfg_psc;
  logic [14:0] cfg_ref;
  logic        cfg_pol, cfg_hiz, cfg_lock_inv;
  logic        mod_ctl, fb_pulse, ref_pulse, pump_up, pump_dn, pump_en, lock_det, cfg_err;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, fb_cyc = 0, ref_cyc = 0, last_iv = 0, ref_iv = 0;
  int fb_seen = 0, ref_seen = 0, long_n = 0, last_long = 0;
  int up_n = 0, dn_n = 0, rem = 0, nmod = 8, ref_step = 1, refph = 0;
  bit bad = 0, last_bad = 0, short_seen = 0, psc_on = 0, ref_on = 0, done = 0;

  synth_divider_core dut_i (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .ref_tick(ref_tick),
    .cfg_div(cfg_div), .cfg_psc(cfg_psc), .cfg_ref(cfg_ref), .cfg_pol(cfg_pol),
    .cfg_hiz(cfg_hiz), .cfg_lock_inv(cfg_lock_inv), .mod_ctl(mod_ctl),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_en(pump_en), .lock_det(lock_det), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int modulus(input logic [2:0] c);
    if (!c[2]) return 8;
    return 16 << c[1:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural prescaler, reference source and observers, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (fb_pulse) begin
      last_iv = cyc - fb_cyc; fb_cyc = cyc;
      last_long = long_n; last_bad = bad;
      long_n = 0; bad = 0; short_seen = 0;
      fb_seen++;
    end
    if (ref_pulse) begin
      ref_iv = cyc - ref_cyc; ref_cyc = cyc; ref_seen++;
    end
    if (pump_up) up_n++;
    if (pump_dn) dn_n++;
    if (psc_on) begin
      if (rem == 0) begin
        if (mod_ctl) begin
          rem = nmod + 1; long_n++;
          if (short_seen) bad = 1;
        end else begin
          rem = nmod; short_seen = 1;
        end
      end
      pre_tick = (rem == 1);
      rem--;
    end else begin
      pre_tick = 1'b0;
    end
    if (ref_on) begin
      ref_tick = (refph == 0);
      refph = (refph + 1) % ref_step;
    end else begin
      ref_tick = 1'b0;
    end
  end

  task automatic set_div(input int m, input int a, input logic [2:0] psc);
    @(negedge clk);
    cfg_div = {11'(m), 7'(a)};
    cfg_psc = psc;
    nmod = modulus(psc);
  endtask

  task automatic wait_fb(input int k);
    int s = fb_seen;
    wait (fb_seen >= s + k);
  endtask

  task automatic wait_ref(input int k);
    int s = ref_seen;
    wait (ref_seen >= s + k);
  endtask

  task automatic chk_fb(input int m, input int a, input logic [2:0] psc);
    int n = modulus(psc);
    set_div(m, a, psc);
    wait_fb(2);
    check("R2 feedback period", last_iv, m * n + a);
    check("R3 N+1 cycles per period", last_long, a);
    check("R3 N+1 cycles lead", int'(last_bad), 0);
  endtask

  task automatic pump_window(input int settle, input int span);
    repeat (settle) @(negedge clk);
    up_n = 0; dn_n = 0;
    repeat (span) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pre_tick = 1'b0; ref_tick = 1'b0;
    cfg_div = {11'd40, 7'd0}; cfg_psc = 3'b000; cfg_ref = 15'd20;
    cfg_pol = 1'b0; cfg_hiz = 1'b0; cfg_lock_inv = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 mod_ctl in reset", int'(mod_ctl), 0);
    check("R1 pumps in reset", int'(pump_up | pump_dn), 0);
    check("R1 pump_en in reset", int'(pump_en), 1);
    check("R11 lock_det in reset", int'(lock_det), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pulses after reset", int'(fb_pulse | ref_pulse), 0);
    check("R1 pumps after reset", int'(pump_up | pump_dn), 0);
    cfg_lock_inv = 1'b1;
    @(negedge clk);
    check("R11 inverted unlocked", int'(lock_det), 1);
    cfg_lock_inv = 1'b0;

    // R9: matched 320-cycle periods, reference strobe every 16 cycles
    ref_step = 16; refph = 0; rem = 0;
    psc_on = 1; ref_on = 1;
    repeat (3000) @(negedge clk);
    check("R9 no lock before 16 periods", int'(lock_det), 0);
    repeat (3500) @(negedge clk);
    check("R9 lock after 16 periods", int'(lock_det), 1);
    cfg_lock_inv = 1'b1;
    @(negedge clk);
    check("R11 inverted locked", int'(lock_det), 0);
    cfg_lock_inv = 1'b0;
    // R10: frequency offset
    set_div(40, 5, 3'b000);
    repeat (10000) @(negedge clk);
    check("R10 lock lost on offset", int'(lock_det), 0);

    // R6/R7/R8: feedback 40 cycles, reference 100 cycles
    ref_step = 1; refph = 0;
    cfg_ref = 15'd100;
    set_div(5, 0, 3'b000);
    pump_window(400, 2000);
    check("R6 down dominates", int'(dn_n > 4 * up_n), 1);
    check("R6 up pulses occur", int'(up_n > 0), 1);
    cfg_pol = 1'b1;
    pump_window(400, 2000);
    check("R7 swapped sense", int'(up_n > 4 * dn_n), 1);
    cfg_hiz = 1'b1;
    pump_window(10, 2000);
    check("R8 pumps quiet", up_n + dn_n, 0);
    check("R8 pump_en low", int'(pump_en), 0);
    cfg_hiz = 1'b0; cfg_pol = 1'b0;
    @(negedge clk);
    check("R8 pump_en restored", int'(pump_en), 1);

    // R4: code map and illegal swallow counts
    for (int c = 0; c < 8; c++) begin
      int n = modulus(3'(c));
      for (int k = 0; k < 2; k++) begin
        int a = (n - 1 + k > 127) ? 127 : n - 1 + k;
        cfg_psc = 3'(c); cfg_div = {11'd200, 7'(a)};
        @(negedge clk);
        check("R4 cfg_err", int'(cfg_err), int'(a >= n));
      end
    end

    // R2/R3 directed corners
    chk_fb(3, 0, 3'b000);
    chk_fb(5, 5, 3'b100);
    chk_fb(10, 7, 3'b011);
    chk_fb(127, 127, 3'b111);
    // R2/R3/R4 random
    for (int i = 0; i < 8; i++) begin
      int sel = $urandom % 3;
      logic [2:0] psc = (sel == 0) ? {1'b0, 2'($urandom)} : ((sel == 1) ? 3'b100 : 3'b101);
      int n = modulus(psc);
      int a = $urandom % n;
      int m = a + 1 + ($urandom % 20);
      chk_fb(m, a, psc);
    end

    // R5: reference divider
    for (int i = 0; i < 7; i++) begin
      int r = (i == 0) ? 0 : ((i == 1) ? 1 : 1 + ($urandom % 300));
      @(negedge clk);
      cfg_ref = 15'(r);
      wait_ref(2);
      check("R5 reference period", ref_iv, (r == 0) ? 1 : r);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule